// File: doc/BRIEF.md
# AHB Burst Address Sequencer

This block is the address-phase half of a bus master. A client hands it one request: a start address, a transfer size, a burst kind, a direction and, for open-length incrementing bursts, a beat count. The block then drives the address-phase outputs of the AHB bus on its own. It opens the burst with a NONSEQ beat and follows with SEQ beats. For each beat it works out the next address, which either increments or wraps inside a line whose width scales with the transfer size.

The engine holds every address-phase output while the bus signals a wait state. When the client's data path cannot keep up, the engine inserts BUSY cycles. An error response aborts the burst. Once the last beat's address phase has been accepted, or once the burst has been aborted, the block returns the bus to IDLE and pulses a completion flag. A second flag on the same pulse tells an abort apart from a normal end. Data transfer itself is left to the client: the address of one beat is out on the bus while the data of the previous beat moves.

Top module: `burst_addr_seq`

## Requirements
- R1: After synchronous reset the bus transfer type is IDLE (code 00), and done and done_err are low.
- R2: A request pulse is taken only when no burst is active and bus_ready is high. A pulse at any other time has no effect on the bus outputs. A fresh NONSEQ is only ever entered from IDLE.
- R3: The cycle after a request is taken, the bus shows NONSEQ (code 10) at the requested address, with the requested kind, size and direction echoed. This does not depend on src_ready.
- R4: The number of beats per kind code is: 000 gives 1, 011 and 010 give 4, 101 and 100 give 8, 111 and 110 give 16, and 001 gives req_len beats, where a req_len of 0 counts as 1.
- R5: For the incrementing kinds (000, 001, 011, 101, 111), each later beat is SEQ (code 11) at the previous address plus 2^size bytes.
- R6: For the wrapping kinds (010, 100, 110), the address bits at and above bit log2(beats)+size stay fixed. The bits below that position advance by 2^size modulo the window.
- R7: While bus_ready is low and bus_err is low, the address, transfer type, kind, size and direction outputs keep their values.
- R8: When a beat is accepted and src_ready is low, the next cycle shows BUSY (code 01) at the next beat's address. BUSY repeats until src_ready is high, then SEQ is shown at that same address. A BUSY cycle does not count as a beat.
- R9: The cycle after the last beat's address phase is accepted, the bus is IDLE and done is high for exactly one cycle, with done_err low.
- R10: If bus_err is high while a burst is active, the next cycle shows IDLE with done and done_err both high. No further beats of that burst are issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Single-cycle request pulse |
| req_addr | input | AW | Start address of the burst |
| req_size | input | 3 | Transfer size code, beat width is 2^size bytes |
| req_kind | input | 3 | Burst kind code |
| req_len | input | LW | Beat count for the open-length incrementing kind |
| req_write | input | 1 | Direction, 1 for write |
| src_ready | input | 1 | Client data path can take the next beat |
| bus_ready | input | 1 | Bus ready; low extends the current phase |
| bus_err | input | 1 | Error response from the bus |
| bus_addr | output | AW | Address-phase address |
| bus_trans | output | 2 | Transfer type: 00 IDLE, 01 BUSY, 10 NONSEQ, 11 SEQ |
| bus_kind | output | 3 | Burst kind shown on the bus |
| bus_size | output | 3 | Transfer size shown on the bus |
| bus_write | output | 1 | Direction shown on the bus |
| done | output | 1 | One-cycle end-of-burst pulse |
| done_err | output | 1 | Set with done when the burst was aborted |

## Verification
Some rules are checked by assertions on every cycle:
- outputs hold while bus_ready is low,
- done is a single-cycle pulse and always comes with IDLE,
- SEQ never follows IDLE,
- NONSEQ is only entered from IDLE,
- an error always aborts the burst on the next cycle.

Other properties only the bench's scenarios can show: the actual address series for each kind and size, the wrap point for every wrapping length, the exact beat count, and that BUSY cycles leave the series intact. The bench also checks that requests arriving mid-burst or during a wait are lost without trace.

// File: rtl/seq_pkg.sv
package seq_pkg;

  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } trans_e;

  localparam logic [2:0] BK_SINGLE = 3'b000;
  localparam logic [2:0] BK_INCR   = 3'b001;
  localparam logic [2:0] BK_WRAP4  = 3'b010;
  localparam logic [2:0] BK_INCR4  = 3'b011;
  localparam logic [2:0] BK_WRAP8  = 3'b100;
  localparam logic [2:0] BK_INCR8  = 3'b101;
  localparam logic [2:0] BK_WRAP16 = 3'b110;
  localparam logic [2:0] BK_INCR16 = 3'b111;

endpackage

// File: rtl/seq_plan.sv
// Decodes a request into its beat count and the address mask of the
// window the low address bits advance in (all ones for incrementing kinds).
module seq_plan #(
  parameter int AW = 32,
  parameter int LW = 8,
  parameter int CW = 8
) (
  input  logic [2:0]    kind,
  input  logic [2:0]    size,
  input  logic [LW-1:0] len,
  output logic [CW-1:0] beats,
  output logic [AW-1:0] win_mask
);
  import seq_pkg::*;

  logic [2:0] lg;       // log2 of the fixed beat count
  logic       wrapping;
  logic [4:0] wbits;

  always_comb begin
    lg       = 3'd0;
    wrapping = 1'b0;
    beats    = CW'(1);
    unique case (kind)
      BK_SINGLE: begin lg = 3'd0; beats = CW'(1); end
      BK_INCR:   beats = (len == '0) ? CW'(1) : CW'(len);
      BK_WRAP4:  begin lg = 3'd2; wrapping = 1'b1; beats = CW'(4);  end
      BK_INCR4:  begin lg = 3'd2; beats = CW'(4);  end
      BK_WRAP8:  begin lg = 3'd3; wrapping = 1'b1; beats = CW'(8);  end
      BK_INCR8:  begin lg = 3'd3; beats = CW'(8);  end
      BK_WRAP16: begin lg = 3'd4; wrapping = 1'b1; beats = CW'(16); end
      BK_INCR16: begin lg = 3'd4; beats = CW'(16); end
      default:   beats = CW'(1);
    endcase
    wbits    = 5'(lg) + 5'(size);
    win_mask = wrapping ? ((AW'(1) << wbits) - AW'(1)) : {AW{1'b1}};
  end

endmodule

// File: rtl/seq_addr_next.sv
// Next beat address: bits outside the window stay, bits inside advance by 2^size.
module seq_addr_next #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] cur,
  input  logic [2:0]    size,
  input  logic [AW-1:0] win_mask,
  output logic [AW-1:0] nxt
);
  logic [AW-1:0] bumped;

  always_comb begin
    bumped = cur + (AW'(1) << size);
    nxt    = (cur & ~win_mask) | (bumped & win_mask);
  end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int AW = 32,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [2:0]    req_size,
  input  logic [2:0]    req_kind,
  input  logic [LW-1:0] req_len,
  input  logic          req_write,
  input  logic          src_ready,
  input  logic          bus_ready,
  input  logic          bus_err,
  output logic [AW-1:0] bus_addr,
  output logic [1:0]    bus_trans,
  output logic [2:0]    bus_kind,
  output logic [2:0]    bus_size,
  output logic          bus_write,
  output logic          done,
  output logic          done_err
);
  import seq_pkg::*;

  localparam int CW = (LW > 5) ? LW : 5;

  trans_e        trans_q;
  logic [AW-1:0] addr_q, mask_q, plan_mask, addr_nxt;
  logic [2:0]    kind_q, size_q;
  logic          write_q, act_q, done_q, derr_q;
  logic [CW-1:0] left_q, plan_beats;

  seq_plan #(.AW(AW), .LW(LW), .CW(CW)) u_plan (
    .kind     (req_kind),
    .size     (req_size),
    .len      (req_len),
    .beats    (plan_beats),
    .win_mask (plan_mask)
  );

  seq_addr_next #(.AW(AW)) u_next (
    .cur      (addr_q),
    .size     (size_q),
    .win_mask (mask_q),
    .nxt      (addr_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      trans_q <= TR_IDLE;
      addr_q  <= '0;
      mask_q  <= '0;
      kind_q  <= '0;
      size_q  <= '0;
      write_q <= 1'b0;
      act_q   <= 1'b0;
      left_q  <= '0;
      done_q  <= 1'b0;
      derr_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      derr_q <= 1'b0;
      if (act_q && bus_err) begin
        act_q   <= 1'b0;
        trans_q <= TR_IDLE;
        done_q  <= 1'b1;
        derr_q  <= 1'b1;
      end else if (bus_ready) begin
        if (!act_q) begin
          if (req_valid) begin
            act_q   <= 1'b1;
            trans_q <= TR_NONSEQ;
            addr_q  <= req_addr;
            mask_q  <= plan_mask;
            kind_q  <= req_kind;
            size_q  <= req_size;
            write_q <= req_write;
            left_q  <= plan_beats - CW'(1);
          end else begin
            trans_q <= TR_IDLE;
          end
        end else begin
          unique case (trans_q)
            TR_NONSEQ, TR_SEQ: begin
              if (left_q == '0) begin
                act_q   <= 1'b0;
                trans_q <= TR_IDLE;
                done_q  <= 1'b1;
              end else begin
                addr_q <= addr_nxt;
                if (src_ready) begin
                  trans_q <= TR_SEQ;
                  left_q  <= left_q - CW'(1);
                end else begin
                  trans_q <= TR_BUSY;
                end
              end
            end
            TR_BUSY: begin
              if (src_ready) begin
                trans_q <= TR_SEQ;
                left_q  <= left_q - CW'(1);
              end
            end
            default: trans_q <= TR_IDLE;
          endcase
        end
      end
    end
  end

  assign bus_addr  = addr_q;
  assign bus_trans = trans_q;
  assign bus_kind  = kind_q;
  assign bus_size  = size_q;
  assign bus_write = write_q;
  assign done      = done_q;
  assign done_err  = derr_q;

  // Checks start two cycles after reset so $past never sees pre-reset values.
  logic [1:0] live_q;
  always_ff @(posedge clk) begin
    if (rst) live_q <= 2'd0;
    else if (live_q != 2'd2) live_q <= live_q + 2'd1;
  end

  AST_HOLD_ON_WAIT: assert property (@(posedge clk) disable iff (rst || live_q != 2'd2)
    $past(!bus_ready && !bus_err) |-> ($stable(bus_addr) && $stable(bus_trans) &&
      $stable(bus_kind) && $stable(bus_size) && $stable(bus_write))); // R7
  AST_NONSEQ_FROM_IDLE: assert property (@(posedge clk) disable iff (rst || live_q != 2'd2)
    (bus_trans == 2'b10 && !$stable(bus_trans)) |-> $past(bus_trans) == 2'b00); // R2
  AST_SEQ_IN_BURST: assert property (@(posedge clk) disable iff (rst || live_q != 2'd2)
    (bus_trans == 2'b11) |-> $past(bus_trans) != 2'b00); // R8
  AST_DONE_WITH_IDLE: assert property (@(posedge clk) disable iff (rst || live_q != 2'd2)
    done |-> bus_trans == 2'b00); // R9
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst || live_q != 2'd2)
    done |=> !done); // R9
  AST_ERR_ABORTS: assert property (@(posedge clk) disable iff (rst || live_q != 2'd2)
    $past(bus_err && act_q) |-> (bus_trans == 2'b00 && done && done_err)); // R10
  AST_ERR_FLAG_PAIRED: assert property (@(posedge clk) disable iff (rst || live_q != 2'd2)
    done_err |-> done); // R10

endmodule

// File: tb/sim_burst_addr_seq.sv
module sim_burst_addr_seq;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_write, src_ready, bus_ready, bus_err;
  logic [31:0] req_addr;
  logic [2:0]  req_size, req_kind;
  logic [7:0]  req_len;
  logic [31:0] bus_addr;
  logic [1:0]  bus_trans;
  logic [2:0]  bus_kind, bus_size;
  logic        bus_write, done, done_err;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #4 clk = ~clk;  // 125 MHz

  burst_addr_seq #(.AW(32), .LW(8)) u0 (
    .clk, .rst, .req_valid, .req_addr, .req_size, .req_kind, .req_len, .req_write,
    .src_ready, .bus_ready, .bus_err, .bus_addr, .bus_trans, .bus_kind, .bus_size,
    .bus_write, .done, .done_err
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000) begin
      failures = failures + 1;
      $display("FAIL watchdog: run hung, actual=%0d expected<=50000 cycles", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic int nbeats(input logic [2:0] k, input int ln);
    case (k)
      3'b000: return 1;
      3'b001: return (ln == 0) ? 1 : ln;
      3'b010, 3'b011: return 4;
      3'b100, 3'b101: return 8;
      default: return 16;
    endcase
  endfunction

  function automatic logic [31:0] eaddr(input logic [31:0] a, input logic [2:0] sz,
                                        input logic [2:0] k, input int i);
    logic [31:0] step, m;
    int lg;
    step = 32'd1 << sz;
    if (k == 3'b010 || k == 3'b100 || k == 3'b110) begin
      lg = (k == 3'b010) ? 2 : (k == 3'b100) ? 3 : 4;
      m  = (32'd1 << (lg + int'(sz))) - 32'd1;
      return (a & ~m) | ((a + 32'(i) * step) & m);
    end
    return a + 32'(i) * step;
  endfunction

  // Runs one burst; stall adds wait states, bsy withholds src_ready,
  // inj pulses a stray request mid-burst, err_at aborts after that many beats.
  task automatic run_burst(input string tag, input logic [31:0] a, input logic [2:0] sz,
                           input logic [2:0] k, input int ln, input bit wr,
                           input bit stall, input bit bsy, input bit inj, input int err_at);
    int nb = 0;
    int t = 0;
    bit busy_seen = 0;
    bit err_sent = 0;
    bit fin = 0;
    bit pr = 1, pe = 0;
    logic [31:0] p_addr;
    logic [1:0]  p_trans;
    int exp_nb;
    exp_nb = (err_at >= 0) ? err_at : nbeats(k, ln);
    @(negedge clk);
    req_valid = 1; req_addr = a; req_size = sz; req_kind = k; req_len = 8'(ln);
    req_write = wr; bus_ready = 1; bus_err = 0; src_ready = 1;
    @(negedge clk);
    req_valid = 0;
    chk(bus_trans == 2'b10 && bus_addr == a, "R3", "first beat NONSEQ at start", bus_addr, a);
    chk(bus_kind == k && bus_size == sz && bus_write == wr, "R3", "echoed kind/size/dir",
        {25'd0, bus_write, bus_size, bus_kind}, {25'd0, wr, sz, k});
    p_addr = bus_addr; p_trans = bus_trans;
    while (!fin && t < 400) begin
      logic r, e, s;
      if (done) begin
        fin = 1;
        chk(bus_trans == 2'b00, "R9", "IDLE with done", {30'd0, bus_trans}, 32'd0);
        chk(done_err == (err_at >= 0), (err_at >= 0) ? "R10" : "R9", "done_err flag",
            {31'd0, done_err}, {31'd0, err_at >= 0});
        chk(nb == exp_nb, (k == 3'b001) ? "R4" : "R4", "beat count", 32'(nb), 32'(exp_nb));
        if (err_at >= 0) begin
          bus_ready = 1; bus_err = 1;      // second cycle of the error response
          @(negedge clk);
          bus_err = 0;
          chk(!done && bus_trans == 2'b00, "R10", "no beats after abort",
              {30'd0, bus_trans}, 32'd0);
        end
        @(negedge clk);
        chk(!done, "R9", "done lasts one cycle", {31'd0, done}, 32'd0);
      end else begin
        if (!pr && !pe)
          chk(bus_addr == p_addr && bus_trans == p_trans, "R7", "hold during wait",
              bus_addr, p_addr);
        if (bus_trans == 2'b01) busy_seen = 1;
        r = !(stall && (t % 3 == 1));
        s = !(bsy && (t % 4 == 1 || t % 4 == 2));
        e = 0;
        if (err_at >= 0 && nb == err_at && !err_sent) begin
          r = 0; e = 1; err_sent = 1;
        end
        bus_ready = r; bus_err = e; src_ready = s;
        req_valid = inj && (nb == 2);
        if (req_valid) begin req_addr = 32'hDEAD_0000; req_kind = 3'b000; end
        if ((bus_trans == 2'b10 || bus_trans == 2'b11) && r && !e) begin
          chk(bus_addr == eaddr(a, sz, k, nb), tag, "beat address", bus_addr, eaddr(a, sz, k, nb));
          if (nb > 0) chk(bus_trans == 2'b11, tag, "later beat is SEQ", {30'd0, bus_trans}, 32'd3);
          nb = nb + 1;
        end
        pr = r; pe = e; p_addr = bus_addr; p_trans = bus_trans;
        t = t + 1;
        @(negedge clk);
        req_valid = 0;
      end
    end
    if (!fin) chk(0, tag, "burst never finished", 32'(t), 32'd400);
    if (bsy && nbeats(k, ln) > 2) chk(busy_seen, "R8", "BUSY inserted", {31'd0, busy_seen}, 32'd1);
    bus_ready = 1; src_ready = 1; bus_err = 0;
  endtask

  task automatic t_reset;
    rst = 1; req_valid = 0; req_addr = 0; req_size = 0; req_kind = 0; req_len = 0;
    req_write = 0; src_ready = 1; bus_ready = 1; bus_err = 0;
    repeat (3) @(negedge clk);
    chk(bus_trans == 2'b00, "R1", "reset IDLE", {30'd0, bus_trans}, 32'd0);
    chk(!done && !done_err, "R1", "reset done low", {30'd0, done, done_err}, 32'd0);
    rst = 0;
    @(negedge clk);
  endtask

  task automatic t_single;   run_burst("R4", 32'h0000_0040, 3'd2, 3'b000, 0, 1, 0, 0, 0, -1); endtask
  task automatic t_incr4;    run_burst("R5", 32'h0000_0100, 3'd2, 3'b011, 0, 0, 0, 0, 0, -1); endtask
  task automatic t_wrap4;    run_burst("R6", 32'h0000_0038, 3'd2, 3'b010, 0, 0, 0, 0, 0, -1); endtask
  task automatic t_wrap8;    run_burst("R6", 32'h0000_1006, 3'd1, 3'b100, 0, 1, 0, 0, 0, -1); endtask
  task automatic t_wrap16;   run_burst("R6", 32'h0000_02F3, 3'd0, 3'b110, 0, 0, 0, 0, 0, -1); endtask
  task automatic t_incr_len; run_burst("R5", 32'h0000_0202, 3'd1, 3'b001, 5, 0, 1, 0, 0, -1); endtask
  task automatic t_incr_zero;run_burst("R4", 32'h0000_0300, 3'd2, 3'b001, 0, 0, 0, 0, 0, -1); endtask
  task automatic t_incr16;   run_burst("R4", 32'h0000_0FF0, 3'd2, 3'b111, 0, 0, 0, 0, 0, -1); endtask
  task automatic t_busy8;    run_burst("R8", 32'h0000_0400, 3'd2, 3'b101, 0, 1, 1, 1, 0, -1); endtask
  task automatic t_busywrap; run_burst("R8", 32'h0000_0518, 3'd3, 3'b100, 0, 0, 1, 1, 0, -1); endtask
  task automatic t_midreq;   run_burst("R2", 32'h0000_0600, 3'd2, 3'b011, 0, 0, 0, 0, 1, -1); endtask
  task automatic t_error;    run_burst("R10", 32'h0000_0700, 3'd2, 3'b111, 0, 0, 1, 0, 0, 3); endtask

  task automatic t_req_in_wait;
    @(negedge clk);
    req_valid = 1; req_addr = 32'h0000_0800; req_kind = 3'b000; req_size = 3'd2; bus_ready = 0;
    @(negedge clk);
    req_valid = 0; bus_ready = 1;
    chk(bus_trans == 2'b00, "R2", "request during wait ignored", {30'd0, bus_trans}, 32'd0);
    @(negedge clk);
    chk(bus_trans == 2'b00 && !done, "R2", "still IDLE", {30'd0, bus_trans}, 32'd0);
  endtask

  initial begin
    t_reset();
    t_single();
    t_incr4();
    t_wrap4();
    t_wrap8();
    t_wrap16();
    t_incr_len();
    t_incr_zero();
    t_incr16();
    t_busy8();
    t_busywrap();
    t_midreq();
    t_req_in_wait();
    t_error();
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule